// File: doc/BRIEF.md
# Branch Target Buffer

This block gives the fetch stage a complete next fetch address in the same cycle that a fetch address is presented, using nothing but that address. It is a direct-mapped table. Each entry holds a valid flag, an address tag and a branch target. A lookup takes the entry picked by the low word-address bits of the fetch PC and compares its tag in full against the upper PC bits. The next PC is the stored target only when that compare hits and the externally supplied direction prediction says taken. In every other case it is the sequential address PC+4.

When a branch resolves as taken, the back end reports its address and target on the update port. The entry at that branch's index is then written, whatever it held before. Resolved not-taken branches leave the table alone. The direction prediction comes from outside this block.

The next-PC selector has two named outcomes. SEQ (PC+4) is chosen on a miss, or on a hit with a not-taken prediction. TARGET (the stored target) is chosen on a hit with a taken prediction. The table has no other state beyond the per-entry valid flags. Reset clears every flag. The transition *fill* sets an entry's flag when a taken branch is written. The transition *evict* replaces an entry's tag and target when a different branch with the same index is written.

Top module: `btb_top`

## Requirements
- R1: After reset, and until the first taken update, every lookup misses (`lk_hit` = 0) and `nxt_pc` = `lk_pc` + 4.
- R2: The entry index is `lk_pc[IDX_W+1:2]` and the tag is `lk_pc[PC_W-1:IDX_W+2]`. A hit requires a valid entry whose stored tag equals the full tag, so an address with a matching index but a different tag misses. Bits [1:0] take part in neither.
- R3: On a hit with `lk_taken_pred` = 1, `nxt_pc` equals the target stored in the entry, in the same cycle.
- R4: On a miss, or when `lk_taken_pred` = 0, `nxt_pc` = `lk_pc` + 4 modulo 2^PC_W.
- R5: An update with `up_valid` = 1 and `up_taken` = 1 writes the tag and target of `up_pc` into its indexed entry and marks it valid. A lookup of that address in any later cycle hits and returns `up_target`.
- R6: A taken update to an index that already holds another tag replaces that entry, so the old address misses afterwards.
- R7: An update with `up_taken` = 0 has no effect on the table.
- R8: A lookup in the same cycle as a write to the same entry sees the contents from before the write.
- R9: `lk_hit` reports the tag hit independently of `lk_taken_pred`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_taken_pred | input | 1 | Direction prediction for this fetch, 1 = taken |
| lk_hit | output | 1 | Valid entry with matching tag |
| nxt_pc | output | PC_W | Next fetch address |
| up_valid | input | 1 | A branch resolution is reported this cycle |
| up_taken | input | 1 | The resolved branch was taken |
| up_pc | input | PC_W | Address of the resolved branch |
| up_target | input | PC_W | Resolved target address |

## Verification
The bench builds the block with 32-bit addresses and only eight entries (IDX_W = 3). With so few entries, random traffic over three tags lands on occupied indexes often, so evictions, aliasing misses and writes that coincide with a lookup of the same entry happen many times per run rather than rarely. The 32-bit width keeps the wrap of PC+4 at the top of the address space within reach of a directed case. The bench also drives random values in the low two PC bits to show that they play no part in the index or the tag.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Source chosen for the next fetch address
    typedef enum logic {
        NPC_SEQ    = 1'b0,
        NPC_TARGET = 1'b1
    } npc_src_e;

    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned OFFS_W     = 2;

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 6,
    localparam int unsigned TAG_W = PC_W - IDX_W - btb_pkg::OFFS_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    localparam int unsigned IDX_LO = btb_pkg::OFFS_W;
    localparam int unsigned TAG_LO = IDX_LO + IDX_W;

    logic unused_offs;

    assign idx         = pc[TAG_LO-1:IDX_LO];
    assign tag         = pc[PC_W-1:TAG_LO];
    assign unused_offs = ^pc[IDX_LO-1:0];
endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned TAG_W = 24,
    localparam int unsigned ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_tgt
);
    logic             vld_q [ENTRIES];
    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [PC_W-1:0]  tgt_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        // valid flag: cleared on reset, set on fill
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[e] <= 1'b0;
            end else if (sel) begin
                vld_q[e] <= 1'b1;
            end
        end

        // payload: fill or evict overwrites tag and target
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[e] <= wr_tag;
                tgt_q[e] <= wr_tgt;
            end
        end
    end

    // read is combinational from the registers: a same-cycle write is not visible
    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_tgt   = tgt_q[rd_idx];
endmodule

// File: rtl/btb_next_pc_sel.sv
module btb_next_pc_sel
    import btb_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic [PC_W-1:0] pc,
    input  logic            hit,
    input  logic            taken,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] nxt
);
    npc_src_e src;

    always_comb begin
        src = (hit && taken) ? NPC_TARGET : NPC_SEQ;
    end

    always_comb begin
        unique case (src)
            NPC_TARGET: nxt = target;
            NPC_SEQ:    nxt = pc + PC_W'(INSN_BYTES);
            default:    nxt = pc + PC_W'(INSN_BYTES);
        endcase
    end
endmodule

// File: rtl/btb_top.sv
module btb_top #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_taken_pred,
    output logic            lk_hit,
    output logic [PC_W-1:0] nxt_pc,
    input  logic            up_valid,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_pc,
    input  logic [PC_W-1:0] up_target
);
    localparam int unsigned TAG_W = PC_W - IDX_W - btb_pkg::OFFS_W;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag, rd_tag;
    logic [PC_W-1:0]  rd_tgt;
    logic             rd_valid;
    logic             fill;

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_split (
        .pc  (lk_pc),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_split (
        .pc  (up_pc),
        .idx (up_idx),
        .tag (up_tag)
    );

    // only resolved taken branches are recorded
    assign fill = up_valid && up_taken;

    btb_entry_array #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill),
        .wr_idx   (up_idx),
        .wr_tag   (up_tag),
        .wr_tgt   (up_target),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt)
    );

    // full tag compare
    assign lk_hit = rd_valid && (rd_tag == lk_tag);

    btb_next_pc_sel #(.PC_W(PC_W)) u_sel (
        .pc     (lk_pc),
        .hit    (lk_hit),
        .taken  (lk_taken_pred),
        .target (rd_tgt),
        .nxt    (nxt_pc)
    );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken_pred,
    input logic            lk_hit,
    input logic [PC_W-1:0] nxt_pc,
    input logic            up_valid,
    input logic            up_taken,
    input logic [PC_W-1:0] up_pc,
    input logic [PC_W-1:0] up_target
);
    logic armed_q;
    logic wrote_q;
    logic unused_lo;

    assign unused_lo = ^up_pc[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            wrote_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (up_valid && up_taken) wrote_q <= 1'b1;
        end
    end

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !wrote_q |-> !lk_hit); // R1

    AST_SEQ_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_hit || !lk_taken_pred) |-> nxt_pc == lk_pc + PC_W'(4)); // R4

    AST_REDIRECT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_taken_pred && nxt_pc != lk_pc + PC_W'(4)) |-> lk_hit); // R3

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(up_valid && up_taken)
         && lk_pc[PC_W-1:2] == $past(up_pc[PC_W-1:2])) |-> lk_hit); // R5

    AST_FILL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(up_valid && up_taken) && lk_taken_pred
         && lk_pc[PC_W-1:2] == $past(up_pc[PC_W-1:2])) |-> nxt_pc == $past(up_target)); // R3
endmodule

bind btb_top btb_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_btb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_pc         (lk_pc),
    .lk_taken_pred (lk_taken_pred),
    .lk_hit        (lk_hit),
    .nxt_pc        (nxt_pc),
    .up_valid      (up_valid),
    .up_taken      (up_taken),
    .up_pc         (up_pc),
    .up_target     (up_target)
);

// File: tb/tb_btb_top.sv
`timescale 1ns/1ps
module tb_btb_top;
    localparam int unsigned PC_W  = 32;
    localparam int unsigned IDX_W = 3;
    localparam int unsigned ENT   = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken_pred = 1'b0;
    logic            lk_hit;
    logic [PC_W-1:0] nxt_pc;
    logic            up_valid = 1'b0;
    logic            up_taken = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic [PC_W-1:0] up_target = '0;

    int unsigned nchk = 0;
    int unsigned nerr = 0;
    bit          done = 1'b0;

    // reference table
    bit              m_vld [ENT];
    logic [PC_W-1:0] m_tag [ENT];
    logic [PC_W-1:0] m_tgt [ENT];

    always #4 clk = ~clk;

    btb_top #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken_pred(lk_taken_pred),
        .lk_hit(lk_hit), .nxt_pc(nxt_pc), .up_valid(up_valid), .up_taken(up_taken),
        .up_pc(up_pc), .up_target(up_target)
    );

    function automatic int unsigned f_idx(logic [PC_W-1:0] pc);
        return int'((pc >> 2) & (ENT - 1));
    endfunction

    function automatic logic [PC_W-1:0] f_tag(logic [PC_W-1:0] pc);
        return pc >> (IDX_W + 2);
    endfunction

    function automatic logic f_hit(logic [PC_W-1:0] pc);
        return m_vld[f_idx(pc)] && (m_tag[f_idx(pc)] == f_tag(pc));
    endfunction

    function automatic logic [PC_W-1:0] f_next(logic [PC_W-1:0] pc, logic tk);
        return (f_hit(pc) && tk) ? m_tgt[f_idx(pc)] : pc + 32'd4;
    endfunction

    task automatic chk(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h (pc=%h)", req, act, exp, lk_pc);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // one cycle: drive at negedge, compare combinational outputs, then commit model
    task automatic step(string req, logic [PC_W-1:0] lpc, logic tk, logic uv,
                        logic ut, logic [PC_W-1:0] upc, logic [PC_W-1:0] utg);
        @(negedge clk);
        lk_pc = lpc; lk_taken_pred = tk;
        up_valid = uv; up_taken = ut; up_pc = upc; up_target = utg;
        #1;
        chk({req, " hit"}, PC_W'(lk_hit), PC_W'(f_hit(lpc)));
        chk({req, " next"}, nxt_pc, f_next(lpc, tk));
        if (uv && ut) begin
            m_vld[f_idx(upc)] = 1'b1;
            m_tag[f_idx(upc)] = f_tag(upc);
            m_tgt[f_idx(upc)] = utg;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired, requirements R1 to R9 unfinished");
        summary();
    end

    initial begin
        logic [PC_W-1:0] pa, pb, pc2;
        for (int i = 0; i < int'(ENT); i++) m_vld[i] = 1'b0;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty table after reset, even with taken prediction
        for (int i = 0; i < int'(ENT); i++)
            step("R1", PC_W'(i << 2) | 32'h0000_0100, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R1 no hit", PC_W'(lk_hit), 32'd0);

        pa = 32'h0000_1234 & ~32'h3;
        // R8: write and lookup of the same entry in one cycle sees old contents
        step("R8", pa, 1'b1, 1'b1, 1'b1, pa, 32'h0000_8000);
        // R5 / R3: following cycle hits and redirects
        step("R5", pa, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R3 target", nxt_pc, 32'h0000_8000);
        // R9 / R4: hit but predicted not taken
        step("R4", pa | 32'h3, 1'b0, 1'b0, 1'b0, '0, '0);
        chk("R9 hit w/o taken", PC_W'(lk_hit), 32'd1);
        chk("R4 seq on not-taken", nxt_pc, (pa | 32'h3) + 32'd4);

        // R7: resolved not-taken branch leaves its entry empty
        pb = 32'h0000_2018;
        step("R7", pb, 1'b1, 1'b1, 1'b0, pb, 32'h0000_9000);
        step("R7", pb, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R7 still miss", PC_W'(lk_hit), 32'd0);

        // R6: same index, other tag evicts
        pc2 = pa + (32'd1 << (IDX_W + 2));
        step("R6", pc2, 1'b1, 1'b1, 1'b1, pc2, 32'h0000_A000);
        step("R6", pa, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R6 old evicted", PC_W'(lk_hit), 32'd0);
        step("R6", pc2, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R6 new target", nxt_pc, 32'h0000_A000);

        // R2: same tag, different index misses; upper tag bit differs misses
        step("R2", pc2 ^ 32'h4, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R2 index differs", PC_W'(lk_hit), 32'd0);
        step("R2", pc2 ^ 32'h8000_0000, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R2 top tag bit", PC_W'(lk_hit), 32'd0);

        // R4: sequential address wraps
        step("R4", 32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R4 wrap", nxt_pc, 32'h0000_0000);

        // random traffic over a small tag pool
        for (int n = 0; n < 4000; n++) begin
            logic [PC_W-1:0] l, u;
            l = (PC_W'($urandom_range(0, 2)) << (IDX_W + 2)) |
                (PC_W'($urandom_range(0, ENT - 1)) << 2) | PC_W'($urandom_range(0, 3));
            u = (PC_W'($urandom_range(0, 2)) << (IDX_W + 2)) |
                (PC_W'($urandom_range(0, ENT - 1)) << 2) | PC_W'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) u = l;
            step("R5/R6/R8 random", l, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), u, $urandom());
        end

        // R1: reset clears everything again
        @(negedge clk) rst_n = 1'b0;
        for (int i = 0; i < int'(ENT); i++) m_vld[i] = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        step("R1 after re-reset", pc2, 1'b1, 1'b0, 1'b0, '0, '0);
        summary();
    end
endmodule